// File: doc/BRIEF.md
# Locked-update PWM generator

A single-channel, left-aligned pulse-width modulator driven through a small 32-bit register bus. The bus has a byte address, a write strobe, write data and a combinational read-data return. Software programs a period and a duty count, both in clock ticks with no prescaling. It also programs a control word. That word starts the channel and sets the output level used during the duty phase and the level used outside it.

Values written to the period and duty registers are staged first. They move into the working set used by the counter and comparator only at a period boundary, so a running cycle is never cut short or stretched. A lock bit in the control word blocks even that transfer. Software sets the lock, writes a new period and duty, and then clears the lock in the same control write that carries new polarity bits. All three take effect together at the start of the following period.

Top module: `pwm_lockreg`

## Requirements
- R1: After reset every register reads zero, the channel is stopped and `pwm_out` is low.
- R2: Reads return the live count at byte offset 0x00. They return the last written period at 0x04, duty at 0x08 and control word at 0x0C. Writes to 0x00 have no effect on the count.
- R3: The channel runs only when control bits 0 and 1 are both 1 and bits 5 and 8 are both 0. Any other combination keeps it stopped.
- R4: While running, the count steps 0, 1, ..., P-1 and wraps to 0, where P is the working period. While stopped, the count holds at 0, and after a start it begins at 0.
- R5: While running, the output takes control bit 3 (the duty level) when count < D and bit 4 (the idle level) otherwise, where D is the working duty. D >= P gives the duty level for the whole cycle, and D = 0 never gives it.
- R6: While stopped and unlocked, the output shows the idle level of control bit 4, from the second clock edge after the control write.
- R7: While running and unlocked, a new period or duty written in mid-cycle leaves the current cycle unchanged. It becomes the working value at the next wrap.
- R8: While control bit 6 (lock) is set, the working period, duty and both levels do not change, whatever is written.
- R9: When the lock is cleared, the staged period and duty take effect at the next period start. So do the polarity bits written in the clearing control write. None of them applies earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick is one count step |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address; bits [3:2] pick the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The embedded properties check the counter and working-set rules. They assume the bus only decodes address bits [3:2], so unaligned low bits are don't-care, and that at most one register is written per cycle. The stimulus uses only word-aligned offsets and drops the write strobe at the falling edge after each write. The sweeps cover every period from 1 to 6 against every duty from 0 to 7 under both polarities. Each working period is written while the channel is stopped, so the expected waveform starts from a known count of 0.

// File: rtl/pwm_lockreg.sv
module pwm_lockreg #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out
);
  localparam int B_EN   = 0;
  localparam int B_CONT = 1;
  localparam int B_DLVL = 3;
  localparam int B_ILVL = 4;
  localparam int B_CTR  = 5;
  localparam int B_LOCK = 6;
  localparam int B_LP   = 8;
  localparam int IW     = AW - 2;

  logic [DW-1:0] ctrl_q, per_stg, duty_stg, per_act, duty_act, cnt;
  logic          dlvl_act, ilvl_act;

  wire [IW-1:0] widx    = bus_addr[AW-1:2];
  wire          running = ctrl_q[B_EN] & ctrl_q[B_CONT] & ~ctrl_q[B_CTR] & ~ctrl_q[B_LP];
  wire          locked  = ctrl_q[B_LOCK];
  wire [DW:0]   cnt_inc = {1'b0, cnt} + 1'b1;
  wire          wrap    = cnt_inc >= {1'b0, per_act};
  wire          commit  = ~locked & (~running | wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      per_stg  <= '0;
      duty_stg <= '0;
      per_act  <= '0;
      duty_act <= '0;
      dlvl_act <= 1'b0;
      ilvl_act <= 1'b0;
      cnt      <= '0;
    end else begin
      if (bus_we) begin
        if (widx == IW'(1)) per_stg  <= bus_wdata;
        if (widx == IW'(2)) duty_stg <= bus_wdata;
        if (widx == IW'(3)) ctrl_q   <= bus_wdata;
      end
      if (commit) begin
        per_act  <= per_stg;
        duty_act <= duty_stg;
        dlvl_act <= ctrl_q[B_DLVL];
        ilvl_act <= ctrl_q[B_ILVL];
      end
      cnt <= (!running || wrap) ? '0 : cnt_inc[DW-1:0];
    end
  end

  always_comb begin
    case (widx)
      IW'(0):  bus_rdata = cnt;
      IW'(1):  bus_rdata = per_stg;
      IW'(2):  bus_rdata = duty_stg;
      IW'(3):  bus_rdata = ctrl_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pwm_out = (running && cnt < duty_act) ? dlvl_act : ilvl_act;

  a_r4_stop_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> cnt == '0);

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (running && per_act != '0) |-> cnt < per_act);

  a_r8_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(per_act) && $stable(duty_act) && $stable(dlvl_act) && $stable(ilvl_act)));

  a_r7_no_midcycle_change: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_inc < {1'b0, per_act}) |=> ($stable(per_act) && $stable(duty_act)));

  a_r5_zero_duty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> pwm_out == ilvl_act);
endmodule

// File: tb/tb_pwm_lockreg.sv
module tb_pwm_lockreg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int vecs = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  pwm_lockreg dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd_chk(input string r, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1 chk(r, bus_rdata, exp);
    bus_addr = 4'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int e, mp, md;
    logic ml, il;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1", 4'h0, 0); rd_chk("R1", 4'h4, 0);
    rd_chk("R1", 4'h8, 0); rd_chk("R1", 4'hC, 0);
    chk("R1", {31'b0, pwm_out}, 0);
    @(negedge clk);

    // R2 readback
    wr(4'h4, 32'hDEAD_0005); rd_chk("R2", 4'h4, 32'hDEAD_0005);
    wr(4'h8, 32'h1234_0002); rd_chk("R2", 4'h8, 32'h1234_0002);
    wr(4'hC, 32'h0000_0010); rd_chk("R2", 4'hC, 32'h10);

    // R6 stopped output follows idle level
    @(negedge clk);
    #1 chk("R6", {31'b0, pwm_out}, 1); chk("R4", bus_rdata, 0);
    wr(4'hC, 32'h0);
    #1 chk("R6", {31'b0, pwm_out}, 1);
    @(negedge clk);
    #1 chk("R6", {31'b0, pwm_out}, 0);

    // R3 running only with bits 0,1 set and 5,8 clear
    wr(4'h4, 5); wr(4'h8, 2);
    wr(4'hC, 32'h2B);
    for (int k = 0; k < 4; k++) begin
      #1 chk("R3", bus_rdata, 0); chk("R3", {31'b0, pwm_out}, 0);
      @(negedge clk);
    end
    wr(4'hC, 32'h10B);
    for (int k = 0; k < 4; k++) begin
      #1 chk("R3", bus_rdata, 0); chk("R3", {31'b0, pwm_out}, 0);
      @(negedge clk);
    end
    wr(4'hC, 32'h09);
    for (int k = 0; k < 4; k++) begin
      #1 chk("R3", bus_rdata, 0);
      @(negedge clk);
    end

    // R4/R5 sweep of period, duty and polarity
    for (int pol = 0; pol < 2; pol++) begin
      for (int p = 1; p <= 6; p++) begin
        for (int d = 0; d <= 7; d++) begin
          logic dl, idl;
          logic [31:0] cp;
          cp = (pol == 1) ? 32'h10 : 32'h08;
          dl = (pol == 0); idl = (pol == 1);
          wr(4'hC, cp); wr(4'h4, p); wr(4'h8, d); wr(4'hC, cp | 32'h3);
          for (int k = 0; k < 2 * p; k++) begin
            #1 chk("R4", bus_rdata, k % p);
            chk("R5", {31'b0, pwm_out}, {31'b0, ((k % p) < d) ? dl : idl});
            @(negedge clk);
          end
        end
      end
    end

    // R7 unlocked mid-cycle period change waits for the wrap; R2 counter write ignored
    wr(4'hC, 32'h08); wr(4'h4, 8); wr(4'h8, 2); wr(4'hC, 32'h0B);
    @(negedge clk);
    wr(4'h4, 3);
    wr(4'h0, 32'h55);
    e = 3; mp = 8;
    for (int k = 0; k < 14; k++) begin
      #1 chk("R7", bus_rdata, e);
      chk("R7", {31'b0, pwm_out}, {31'b0, e < 2});
      @(negedge clk);
      if (e + 1 >= mp) begin e = 0; mp = 3; end else e = e + 1;
    end

    // R8 lock freezes the working set, R9 unlock commits together at next period start
    wr(4'hC, 32'h08); wr(4'h4, 4); wr(4'h8, 1); wr(4'hC, 32'h0B);
    wr(4'hC, 32'h4B); wr(4'h4, 6); wr(4'h8, 3);
    rd_chk("R2", 4'h8, 3);
    e = 3; mp = 4; md = 1; ml = 1'b1; il = 1'b0;
    for (int k = 0; k < 8; k++) begin
      #1 chk("R8", bus_rdata, e);
      chk("R8", {31'b0, pwm_out}, {31'b0, (e < md) ? ml : il});
      @(negedge clk);
      e = (e + 1 >= mp) ? 0 : e + 1;
    end
    wr(4'hC, 32'h13);
    e = (e + 1 >= mp) ? 0 : e + 1;
    for (int k = 0; k < 16; k++) begin
      #1 chk("R9", bus_rdata, e);
      chk("R9", {31'b0, pwm_out}, {31'b0, (e < md) ? ml : il});
      @(negedge clk);
      if (e + 1 >= mp) begin
        e = 0; mp = 6; md = 3; ml = 1'b0; il = 1'b1;
      end else e = e + 1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule